// File: doc/BRIEF.md
# Addressed Frame Receiver with Checksum and Station Match

This block sits after a byte-level UART receiver and turns its byte stream into addressed messages. It looks for a start byte, reads a length byte and a 16-bit destination, then a command byte, up to a parameterised number of payload bytes, and a trailing checksum. The block accepts a frame only if the checksum is correct and the destination selects this station. The station has three loadable identities: a 16-bit main address, an 8-bit group address and an 8-bit short address. The destination space is split into windows, and each window compares against one of these identities. The top page of the space also holds two broadcast codes.

When a frame is accepted, the block pulses an accept strobe for one cycle. It then presents the command byte and the payload length. The payload bytes are read through an indexed read port with one cycle of latency. A length byte out of range or a checksum mismatch raises a one-cycle error strobe, and the parser goes back to looking for a start byte. A frame whose checksum is correct but whose destination does not match is dropped without any strobe.

Top module: `msg_frame_rx`

## Requirements
- R1: While hunting, every received byte other than 0xA5 is discarded with no strobe. Byte 0xA5 starts a frame.
- R2: The byte after 0xA5 is the count of remaining bytes. A count below 4, or above MAX_DATA+4 (22 by default), pulses `frame_err` one cycle after that byte, and the parser returns to hunting.
- R3: After the count come the address high byte, the address low byte and the command byte. Then come count−4 payload bytes and the checksum. On accept, `len_out` = count−4 and `cmd_out` = command. `rd_byte` shows payload byte `rd_idx` (index 0 = first payload byte) one cycle after `rd_idx` is applied, and `len_out` never exceeds MAX_DATA.
- R4: The checksum is the modulo-256 sum of the count, both address bytes, the command byte and the payload. A mismatch pulses `frame_err` and never `frame_ok`.
- R5: A destination below 0xFC00 matches only when it equals the full main address. A main address of 0xFC00 or above therefore cannot be hit directly.
- R6: Destinations 0xFCxx match when xx equals the short address. Destinations 0xFDxx match when xx equals the group address.
- R7: Destinations 0xFExx match when xx equals the main address's upper byte. Destinations 0xFF00–0xFFFD never match.
- R8: Destination 0xFFFF always matches. Destination 0xFFFE matches only while `bcast_mask` is low in the cycle the checksum byte is taken.
- R9: After reset the main address is 0xFF00 and the group and short addresses are 0x00, so 0xFEFF, 0xFD00 and 0xFC00 all match. A load pulse replaces the register value on the next edge.
- R10: `frame_ok` and `frame_err` are single-cycle pulses, never both high at once. They appear one cycle after the byte that decides the frame. An address miss raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| main_load | input | 1 | Load main address |
| main_in | input | 16 | New main address |
| grp_load | input | 1 | Load group address |
| grp_in | input | 8 | New group address |
| short_load | input | 1 | Load short address |
| short_in | input | 8 | New short address |
| bcast_mask | input | 1 | High blocks the maskable broadcast |
| rd_idx | input | $clog2(MAX_DATA+1) | Payload read index |
| rd_byte | output | 8 | Payload byte at rd_idx, one cycle later |
| cmd_out | output | 8 | Command of last accepted frame |
| len_out | output | $clog2(MAX_DATA+1) | Payload count of last accepted frame |
| frame_ok | output | 1 | Frame accepted pulse |
| frame_err | output | 1 | Bad count or checksum pulse |

## Verification
Some properties are checked on every cycle:
- The two strobes are one-cycle pulses and never coincide.
- An accepted frame never reports more payload than the buffer holds.
- No accept ever comes from the reserved 0xFF00–0xFFFD codes, or from the maskable broadcast while the mask was high.
- The address registers hold their reset values and follow load pulses.

The window decoding, the checksum arithmetic, the count bounds and the payload order can only be shown by the bench's scenarios. The bench compares frames, whether random or built for a particular window, against a reference match function and a reference sum. This includes the direct-compare blind spot above 0xFBFF and resynchronisation after junk bytes and aborted frames.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  localparam logic [7:0]  SOF_BYTE     = 8'hA5;
  localparam logic [15:0] DIRECT_TOP   = 16'hFC00;
  localparam logic [7:0]  PG_SHORT     = 8'hFC;
  localparam logic [7:0]  PG_GROUP     = 8'hFD;
  localparam logic [7:0]  PG_MAIN_HI   = 8'hFE;
  localparam logic [7:0]  PG_BCAST     = 8'hFF;
  localparam logic [7:0]  BC_MASKABLE  = 8'hFE;
  localparam logic [7:0]  BC_ALL       = 8'hFF;
  localparam logic [15:0] MAIN_RST     = 16'hFF00;
  localparam int          HDR_BYTES    = 4;

  typedef enum logic [2:0] {
    ST_HUNT, ST_COUNT, ST_ADDR_HI, ST_ADDR_LO, ST_CMD, ST_DATA, ST_CKS
  } rx_state_t;
endpackage

// File: rtl/msg_addr_regs.sv
module msg_addr_regs
  import msg_rx_pkg::*;
#(
  parameter int MAIN_W = 16,
  parameter int SUB_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_load,
  input  logic [MAIN_W-1:0] main_in,
  input  logic              grp_load,
  input  logic [SUB_W-1:0]  grp_in,
  input  logic              short_load,
  input  logic [SUB_W-1:0]  short_in,
  output logic [MAIN_W-1:0] main_q,
  output logic [SUB_W-1:0]  grp_q,
  output logic [SUB_W-1:0]  short_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q  <= MAIN_W'(MAIN_RST);
      grp_q   <= '0;
      short_q <= '0;
    end else begin
      if (main_load)  main_q  <= main_in;
      if (grp_load)   grp_q   <= grp_in;
      if (short_load) short_q <= short_in;
    end
  end
endmodule

// File: rtl/msg_addr_match.sv
module msg_addr_match
  import msg_rx_pkg::*;
(
  input  logic [15:0] dest,
  input  logic [15:0] main_q,
  input  logic [7:0]  grp_q,
  input  logic [7:0]  short_q,
  input  logic        bcast_mask,
  output logic        hit
);
  logic [7:0] page;
  logic [7:0] low;
  assign page = dest[15:8];
  assign low  = dest[7:0];

  always_comb begin
    hit = 1'b0;
    if (dest < DIRECT_TOP) begin
      hit = (dest == main_q);
    end else begin
      case (page)
        PG_SHORT:   hit = (low == short_q);
        PG_GROUP:   hit = (low == grp_q);
        PG_MAIN_HI: hit = (low == main_q[15:8]);
        PG_BCAST:   hit = (low == BC_ALL) || ((low == BC_MASKABLE) && !bcast_mask);
        default:    hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/msg_frame_parser.sv
module msg_frame_parser
  import msg_rx_pkg::*;
#(
  parameter int MAX_DATA = 18,
  localparam int LEN_W   = $clog2(MAX_DATA + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             addr_hit,
  output logic [15:0]      dest_q,
  input  logic [LEN_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [7:0]       cmd_out,
  output logic [LEN_W-1:0] len_out,
  output logic             frame_ok,
  output logic             frame_err
);
  localparam logic [7:0] CNT_MIN = 8'(HDR_BYTES);
  localparam logic [7:0] CNT_MAX = 8'(MAX_DATA + HDR_BYTES);
  localparam logic [LEN_W-1:0] DEPTH = LEN_W'(MAX_DATA);

  rx_state_t        st_q;
  logic [7:0]       sum_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] n_q;
  logic [LEN_W-1:0] idx_q;
  logic [7:0]       buf_mem [MAX_DATA];
  logic             cnt_bad;
  logic [7:0]       sum_nx;

  assign cnt_bad = (rx_byte < CNT_MIN) || (rx_byte > CNT_MAX);
  assign sum_nx  = sum_q + rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      sum_q     <= '0;
      cmd_q     <= '0;
      dest_q    <= '0;
      n_q       <= '0;
      idx_q     <= '0;
      cmd_out   <= '0;
      len_out   <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (rx_valid) begin
        case (st_q)
          ST_HUNT: begin
            if (rx_byte == SOF_BYTE) st_q <= ST_COUNT;
          end
          ST_COUNT: begin
            if (cnt_bad) begin
              frame_err <= 1'b1;
              st_q      <= ST_HUNT;
            end else begin
              n_q   <= LEN_W'(rx_byte - CNT_MIN);
              sum_q <= rx_byte;
              st_q  <= ST_ADDR_HI;
            end
          end
          ST_ADDR_HI: begin
            dest_q[15:8] <= rx_byte;
            sum_q        <= sum_nx;
            st_q         <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            dest_q[7:0] <= rx_byte;
            sum_q       <= sum_nx;
            st_q        <= ST_CMD;
          end
          ST_CMD: begin
            cmd_q <= rx_byte;
            sum_q <= sum_nx;
            idx_q <= '0;
            st_q  <= (n_q == '0) ? ST_CKS : ST_DATA;
          end
          ST_DATA: begin
            sum_q <= sum_nx;
            idx_q <= idx_q + 1'b1;
            if (idx_q == n_q - 1'b1) st_q <= ST_CKS;
          end
          ST_CKS: begin
            st_q <= ST_HUNT;
            if (rx_byte != sum_q) begin
              frame_err <= 1'b1;
            end else if (addr_hit) begin
              frame_ok <= 1'b1;
              cmd_out  <= cmd_q;
              len_out  <= n_q;
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  // payload store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (rx_valid && (st_q == ST_DATA)) buf_mem[idx_q] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rd_idx < DEPTH) rd_byte <= buf_mem[rd_idx];
    else                rd_byte <= '0;
  end
endmodule

// File: rtl/msg_frame_rx.sv
module msg_frame_rx
  import msg_rx_pkg::*;
#(
  parameter int MAX_DATA = 18
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rx_valid,
  input  logic [7:0]                     rx_byte,
  input  logic                           main_load,
  input  logic [15:0]                    main_in,
  input  logic                           grp_load,
  input  logic [7:0]                     grp_in,
  input  logic                           short_load,
  input  logic [7:0]                     short_in,
  input  logic                           bcast_mask,
  input  logic [$clog2(MAX_DATA+1)-1:0]  rd_idx,
  output logic [7:0]                     rd_byte,
  output logic [7:0]                     cmd_out,
  output logic [$clog2(MAX_DATA+1)-1:0]  len_out,
  output logic                           frame_ok,
  output logic                           frame_err
);
  logic [15:0] main_q;
  logic [7:0]  grp_q;
  logic [7:0]  short_q;
  logic [15:0] dest_q;
  logic        addr_hit;

  msg_addr_regs #(.MAIN_W(16), .SUB_W(8)) i_regs (
    .clk(clk), .rst(rst),
    .main_load(main_load), .main_in(main_in),
    .grp_load(grp_load), .grp_in(grp_in),
    .short_load(short_load), .short_in(short_in),
    .main_q(main_q), .grp_q(grp_q), .short_q(short_q)
  );

  msg_addr_match i_match (
    .dest(dest_q), .main_q(main_q), .grp_q(grp_q), .short_q(short_q),
    .bcast_mask(bcast_mask), .hit(addr_hit)
  );

  msg_frame_parser #(.MAX_DATA(MAX_DATA)) i_parser (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .addr_hit(addr_hit), .dest_q(dest_q),
    .rd_idx(rd_idx), .rd_byte(rd_byte),
    .cmd_out(cmd_out), .len_out(len_out),
    .frame_ok(frame_ok), .frame_err(frame_err)
  );
endmodule

// File: rtl/msg_frame_rx_chk.sv
module msg_frame_rx_chk #(
  parameter int MAX_DATA = 18,
  localparam int LEN_W   = $clog2(MAX_DATA + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_ok,
  input logic             frame_err,
  input logic [LEN_W-1:0] len_out,
  input logic             bcast_mask,
  input logic [15:0]      dest_q,
  input logic             main_load,
  input logic [15:0]      main_in,
  input logic [15:0]      main_q,
  input logic [7:0]       grp_q,
  input logic [7:0]       short_q
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_err)); // R10
  AST_OK_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err); // R10
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> (len_out <= LEN_W'(MAX_DATA))); // R3
  AST_MASKED_BCAST: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && dest_q == 16'hFFFE) |-> !$past(bcast_mask)); // R8
  AST_RESERVED_MISS: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> !(dest_q >= 16'hFF00 && dest_q <= 16'hFFFD)); // R7
  AST_RESET_IDS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (main_q == 16'hFF00 && grp_q == 8'h00 && short_q == 8'h00)); // R9
  AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(main_load) && !$past(rst)) |-> (main_q == $past(main_in))); // R9
endmodule

bind msg_frame_rx msg_frame_rx_chk #(.MAX_DATA(MAX_DATA)) i_chk (
  .clk(clk), .rst(rst), .frame_ok(frame_ok), .frame_err(frame_err),
  .len_out(len_out), .bcast_mask(bcast_mask), .dest_q(dest_q),
  .main_load(main_load), .main_in(main_in), .main_q(main_q),
  .grp_q(grp_q), .short_q(short_q)
);

// File: tb/test_msg_frame_rx.sv
`timescale 1ns/1ps
module test_msg_frame_rx;
  localparam int MAXD  = 18;
  localparam int LW    = $clog2(MAXD + 1);
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic main_load = 1'b0, grp_load = 1'b0, short_load = 1'b0;
  logic [15:0] main_in = '0;
  logic [7:0] grp_in = '0, short_in = '0;
  logic bcast_mask = 1'b0;
  logic [LW-1:0] rd_idx = '0;
  logic [7:0] rd_byte, cmd_out;
  logic [LW-1:0] len_out;
  logic frame_ok, frame_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] m_main = 16'hFF00;
  logic [7:0]  m_grp = 8'h00, m_short = 8'h00;
  logic [7:0]  dbuf [MAXD];
  bit gaps = 1'b0;

  always #4 clk = ~clk;

  msg_frame_rx #(.MAX_DATA(MAXD)) i_msg_frame_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .main_load(main_load), .main_in(main_in), .grp_load(grp_load), .grp_in(grp_in),
    .short_load(short_load), .short_in(short_in), .bcast_mask(bcast_mask),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .cmd_out(cmd_out), .len_out(len_out),
    .frame_ok(frame_ok), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [15:0] a, input bit msk);
    if (a < 16'hFC00)       return a == m_main;
    if (a[15:8] == 8'hFC)   return a[7:0] == m_short;
    if (a[15:8] == 8'hFD)   return a[7:0] == m_grp;
    if (a[15:8] == 8'hFE)   return a[7:0] == m_main[15:8];
    if (a == 16'hFFFF)      return 1'b1;
    if (a == 16'hFFFE)      return !msk;
    return 1'b0;
  endfunction

  // byte taken at the posedge between the two negedges
  task automatic send_byte(input logic [7:0] b);
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic load_ids(input logic [15:0] mv, input logic [7:0] gv, input logic [7:0] sv);
    @(negedge clk);
    main_load = 1'b1; main_in = mv;
    grp_load = 1'b1; grp_in = gv;
    short_load = 1'b1; short_in = sv;
    @(negedge clk);
    main_load = 1'b0; grp_load = 1'b0; short_load = 1'b0;
    m_main = mv; m_grp = gv; m_short = sv;
  endtask

  task automatic frame(input string tag, input logic [15:0] a, input logic [7:0] c,
                       input int n, input bit bad);
    logic [7:0] s;
    bit exp_ok;
    s = 8'(n + 4) + a[15:8] + a[7:0] + c;
    for (int i = 0; i < n; i++) s = s + dbuf[i];
    send_byte(8'hA5);
    send_byte(8'(n + 4));
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(c);
    for (int i = 0; i < n; i++) send_byte(dbuf[i]);
    send_byte(bad ? s + 8'd1 : s);
    exp_ok = !bad && ref_hit(a, bcast_mask);
    chk({tag, " R10 frame_ok"}, 32'(frame_ok), 32'(exp_ok));
    chk({tag, " R4 frame_err"}, 32'(frame_err), 32'(bad));
    if (exp_ok && frame_ok) begin
      chk({tag, " R3 cmd_out"}, 32'(cmd_out), 32'(c));
      chk({tag, " R3 len_out"}, 32'(len_out), 32'(n));
      for (int i = 0; i < n; i++) begin
        rd_idx = LW'(i);
        @(negedge clk);
        chk({tag, " R3 payload"}, 32'(rd_byte), 32'(dbuf[i]));
      end
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
  endtask

  function automatic logic [15:0] pick_addr();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0: return m_main;
      1: return {8'hFC, m_short};
      2: return {8'hFD, m_grp};
      3: return {8'hFE, m_main[15:8]};
      4: return 16'hFFFE;
      5: return 16'hFFFF;
      6: return {8'hFF, 8'($urandom_range(0, 253))};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R9 reset frame_ok", 32'(frame_ok), 32'd0);
    chk("R9 reset frame_err", 32'(frame_err), 32'd0);
    chk("R9 reset len_out", 32'(len_out), 32'd0);

    // reset identities
    fill(3);
    frame("R9 group bcast FEFF", 16'hFEFF, 8'h11, 3, 1'b0);
    frame("R9 group 00", 16'hFD00, 8'h12, 0, 1'b0);
    frame("R9 short 00", 16'hFC00, 8'h13, 1, 1'b0);
    frame("R7 reserved FF00", 16'hFF00, 8'h14, 2, 1'b0);

    // R1 junk while hunting
    for (int i = 0; i < 6; i++) begin
      send_byte((i % 2 == 0) ? 8'h5A : 8'(i * 37));
      chk("R1 junk no strobe", 32'({frame_ok, frame_err}), 32'd0);
    end
    frame("R1 after junk", 16'hFFFF, 8'h20, 2, 1'b0);

    // R2 count bounds
    send_byte(8'hA5); send_byte(8'd3);
    chk("R2 count 3 err", 32'(frame_err), 32'd1);
    send_byte(8'hA5); send_byte(8'd23);
    chk("R2 count 23 err", 32'(frame_err), 32'd1);
    send_byte(8'h00);
    chk("R2 hunting after abort", 32'({frame_ok, frame_err}), 32'd0);
    fill(MAXD);
    frame("R3 full payload", 16'hFFFF, 8'h21, MAXD, 1'b0);
    frame("R3 empty payload", 16'hFFFF, 8'h22, 0, 1'b0);

    // R4 checksum
    fill(5);
    frame("R4 bad sum", 16'hFFFF, 8'h23, 5, 1'b1);

    // R5..R7 loaded identities
    load_ids(16'h1234, 8'h5C, 8'h33);
    frame("R5 direct hit", 16'h1234, 8'h30, 4, 1'b0);
    frame("R5 direct miss", 16'h1235, 8'h31, 4, 1'b0);
    frame("R7 upper byte hit", 16'hFE12, 8'h32, 1, 1'b0);
    frame("R7 old FEFF miss", 16'hFEFF, 8'h33, 1, 1'b0);
    frame("R6 group hit", 16'hFD5C, 8'h34, 2, 1'b0);
    frame("R6 group miss", 16'hFD5D, 8'h35, 2, 1'b0);
    frame("R6 short hit", 16'hFC33, 8'h36, 2, 1'b0);
    frame("R6 short miss", 16'hFC5C, 8'h37, 2, 1'b0);

    // R8 broadcasts
    bcast_mask = 1'b1;
    frame("R8 masked FFFE", 16'hFFFE, 8'h40, 1, 1'b0);
    frame("R8 FFFF under mask", 16'hFFFF, 8'h41, 1, 1'b0);
    bcast_mask = 1'b0;
    frame("R8 unmasked FFFE", 16'hFFFE, 8'h42, 1, 1'b0);

    // R5 blind spot above direct window
    load_ids(16'hFC10, 8'h01, 8'h02);
    frame("R5 FC10 not direct", 16'hFC10, 8'h50, 1, 1'b0);
    frame("R7 FEFC hit", 16'hFEFC, 8'h51, 1, 1'b0);

    // random traffic
    gaps = 1'b1;
    for (int t = 0; t < 150; t++) begin
      int n;
      if ($urandom_range(0, 7) == 0)
        load_ids(16'($urandom), 8'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] j;
        j = 8'($urandom);
        if (j == 8'hA5) j = 8'h5A;
        send_byte(j);
        chk("R1 random junk", 32'({frame_ok, frame_err}), 32'd0);
      end
      bcast_mask = 1'($urandom_range(0, 1));
      n = $urandom_range(0, MAXD);
      fill(n);
      frame("R4 random frame", pick_addr(), 8'($urandom), n, ($urandom_range(0, 4) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule